// File: doc/BRIEF.md
# Dual Blink Generator with Per-Pin Source Selector

This block produces two independent blink waveforms and routes them, or a fixed level, onto two LED pins that can only pull low. Each blink channel divides a common timebase strobe by a programmable prescale value to step an 8-bit phase counter. One full lap of that counter is one blink period. A programmable threshold on the phase sets how much of each lap the channel is active.

A register block outside this one holds the channel settings and the selector byte and presents them as plain inputs. Each pin has a 2-bit field in the selector that picks one of four sources: forced on, released (off), channel 0 or channel 1. The strobe is meant to run at 44 × 256 pulses per second, which gives a period of (PSC+1)/44 seconds. Settings written while a lap is running are held back until the lap completes, so a waveform is never cut short or stretched partway.

Top module: `blink_led_mux`

## Requirements
- R1: While tick_i is high every cycle, a channel's period is 256 × (PSC + 1) clock cycles, measured between successive rising edges of a pin that follows it.
- R2: A channel is active when its phase count is at or above its PWM value. Over one full period it is active for (256 − PWM) × (PSC + 1) strobes: always active at PWM = 00h, and active for one phase step in 256 at PWM = FFh.
- R3: The selector field for pin 0 is sel_i[1:0] and for pin 1 is sel_i[3:2]. Code 00 asserts drive_low_o for that pin (LED on). Code 01 deasserts it (high-impedance, LED off). Each takes effect one cycle after it is applied.
- R4: Code 10 makes the pin follow channel 0 and code 11 makes it follow channel 1. The pin's drive_low_o is asserted one cycle after the chosen channel is active.
- R5: New PSC or PWM values are adopted only when the phase counter wraps from FFh to 00h. A change made mid-period leaves the rest of that period unchanged.
- R6: Reset deasserts both outputs and clears both phase counters. Each channel then runs with PSC = FFh and PWM = 80h for its first period, so the active run lasts 32768 strobes.
- R7: sel_i[7:4] has no effect on either pin.
- R8: When tick_i is low, neither the prescalers nor the phase counters move, so the outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase strobe, one cycle per prescaler step |
| psc0_i | input | 8 | Channel 0 prescale value |
| pwm0_i | input | 8 | Channel 0 duty threshold |
| psc1_i | input | 8 | Channel 1 prescale value |
| pwm1_i | input | 8 | Channel 1 duty threshold |
| sel_i | input | 8 | Pin source selector, 2 bits per pin |
| drive_low_o | output | 2 | Per-pin pull-low enable; 0 means released |

## Verification
The hardest case to reach is a setting change that lands partway through a period. The result has to show the old threshold still in force until the wrap. The bench holds the prescaler at zero and waits for a rising edge on the pin. It then raises the threshold above the current phase and checks that the pin stays asserted for the next 100 cycles. If the new value were taken at once, the pin would drop.

A second hard case is the reset period. It also needs the full default lap of 65536 strobes. The bench loads new settings just before starting the strobe, so that single long lap checks both the defaults and the deferral.

// File: rtl/blink_pkg.sv
package blink_pkg;
  localparam int unsigned PHASE_W = 8;
  localparam int unsigned N_CH    = 2;
  localparam int unsigned N_PINS  = 2;
  localparam int unsigned SEL_W   = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_ON  = 2'b00,
    SEL_OFF = 2'b01,
    SEL_CH0 = 2'b10,
    SEL_CH1 = 2'b11
  } pin_src_e;
endpackage

// File: rtl/blink_chan.sv
module blink_chan #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] psc_i,
  input  logic [W-1:0] pwm_i,
  output logic         active_o
);
  localparam logic [W-1:0] PHASE_MAX = {W{1'b1}};
  localparam logic [W-1:0] PSC_RST   = {W{1'b1}};
  localparam logic [W-1:0] PWM_RST   = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] pre_q, phase_q, psc_q, pwm_q;
  logic         step, wrap;

  assign step = tick_i && (pre_q == psc_q);
  assign wrap = step && (phase_q == PHASE_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q   <= '0;
      phase_q <= '0;
      psc_q   <= PSC_RST;
      pwm_q   <= PWM_RST;
    end else if (tick_i) begin
      pre_q <= step ? '0 : pre_q + 1'b1;
      if (step) phase_q <= phase_q + 1'b1;
      // shadow settings only at lap boundary
      if (wrap) begin
        psc_q <= psc_i;
        pwm_q <= pwm_i;
      end
    end
  end

  assign active_o = (phase_q >= pwm_q);

  assert_hold_no_tick_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(phase_q) && $stable(pre_q)));

  assert_pre_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= psc_q);

  assert_phase_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && pre_q == psc_q) |=> (phase_q == W'($past(phase_q) + 1'b1)));

  assert_cfg_at_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PHASE_MAX || !tick_i) |=> ($stable(pwm_q) && $stable(psc_q)));
endmodule

// File: rtl/led_pin.sv
module led_pin
  import blink_pkg::*;
#(
  parameter int unsigned NC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] code_i,
  input  logic [NC-1:0]    ch_act_i,
  output logic             drive_low_o
);
  logic d;

  always_comb begin
    unique case (pin_src_e'(code_i))
      SEL_ON:  d = 1'b1;
      SEL_OFF: d = 1'b0;
      SEL_CH0: d = ch_act_i[0];
      SEL_CH1: d = ch_act_i[1];
      default: d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drive_low_o <= 1'b0;
    else         drive_low_o <= d;
  end

  assert_on_code_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i == SEL_ON) |=> drive_low_o);

  assert_off_code_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i == SEL_OFF) |=> !drive_low_o);

  assert_follow_ch0_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i == SEL_CH0) |=> (drive_low_o == $past(ch_act_i[0])));

  assert_follow_ch1_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i == SEL_CH1) |=> (drive_low_o == $past(ch_act_i[1])));
endmodule

// File: rtl/blink_led_mux.sv
module blink_led_mux
  import blink_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [PHASE_W-1:0] psc0_i,
  input  logic [PHASE_W-1:0] pwm0_i,
  input  logic [PHASE_W-1:0] psc1_i,
  input  logic [PHASE_W-1:0] pwm1_i,
  input  logic [7:0]         sel_i,
  output logic [N_PINS-1:0]  drive_low_o
);
  logic [PHASE_W-1:0] psc_arr [N_CH];
  logic [PHASE_W-1:0] pwm_arr [N_CH];
  logic [N_CH-1:0]    ch_act;

  assign psc_arr[0] = psc0_i;
  assign psc_arr[1] = psc1_i;
  assign pwm_arr[0] = pwm0_i;
  assign pwm_arr[1] = pwm1_i;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    blink_chan #(.W(PHASE_W)) i_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .psc_i    (psc_arr[c]),
      .pwm_i    (pwm_arr[c]),
      .active_o (ch_act[c])
    );
  end

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    led_pin #(.NC(N_CH)) i_pin (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .code_i      (sel_i[SEL_W*p +: SEL_W]),
      .ch_act_i    (ch_act),
      .drive_low_o (drive_low_o[p])
    );
  end

  assert_rst_quiet_R6: assert property (@(posedge clk_i)
    !rst_ni |=> (drive_low_o == '0));
endmodule

// File: tb/test_blink_led_mux.sv
module test_blink_led_mux;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] psc0 = 8'hFF, pwm0 = 8'h80, psc1 = 8'hFF, pwm1 = 8'h80;
  logic [7:0] sel = 8'h05;
  logic [1:0] drv;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  blink_led_mux i_blink_led_mux (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick),
    .psc0_i(psc0), .pwm0_i(pwm0), .psc1_i(psc1), .pwm1_i(pwm1),
    .sel_i(sel), .drive_low_o(drv)
  );

  // {psc0, pwm0, psc1, pwm1}
  localparam logic [31:0] ROWS [6] = '{
    32'h00_80_00_40,
    32'h01_40_02_C0,
    32'h00_00_01_FF,
    32'h03_FF_00_00,
    32'h02_C0_03_01,
    32'h01_01_00_80
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_active(input int pin, input int len, output int cnt);
    cnt = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (drv[pin]) cnt++;
    end
  endtask

  task automatic wait_rise(input int pin);
    logic prev;
    @(negedge clk);
    prev = drv[pin];
    forever begin
      @(negedge clk);
      if (!prev && drv[pin]) break;
      prev = drv[pin];
    end
  endtask

  task automatic measure_period(input int pin, output int p);
    logic prev;
    wait_rise(pin);
    p = 0;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      p++;
      if (!prev && drv[pin]) break;
      prev = drv[pin];
    end
  endtask

  initial begin
    for (int i = 0; i < 190000; i++) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int v, p, prev_max;
    cycles(3);
    rst_ni = 1'b1;
    cycles(2);
    check(drv == 2'b00, "R6 reset outputs", drv, 0);

    // next settings staged before the default lap completes
    psc0 = 8'h00; pwm0 = 8'h80; psc1 = 8'h00; pwm1 = 8'h40;
    sel = 8'hFE;          // pin0 -> ch0 (10), pin1 -> ch1 (11)
    @(negedge clk);
    tick = 1'b1;
    wait_rise(0);
    check(drv[1] == 1'b1, "R6 both channels default alike", drv[1], 1);
    v = 0;
    while (drv[0]) begin
      v++;
      @(negedge clk);
    end
    check(v == 32768, "R6 R5 default active run", v, 32768);

    prev_max = 0;
    for (int r = 0; r < 6; r++) begin
      int ps [2];
      int pw [2];
      ps[0] = ROWS[r][31:24]; pw[0] = ROWS[r][23:16];
      ps[1] = ROWS[r][15:8];  pw[1] = ROWS[r][7:0];
      psc0 = 8'(ps[0]); pwm0 = 8'(pw[0]); psc1 = 8'(ps[1]); pwm1 = 8'(pw[1]);
      cycles(256 * (prev_max + 1) + 4);
      for (int c = 0; c < 2; c++) begin
        count_active(c, 256 * (ps[c] + 1), v);
        check(v == (256 - pw[c]) * (ps[c] + 1), "R2 R4 active count", v,
              (256 - pw[c]) * (ps[c] + 1));
        if (pw[c] != 0) begin
          measure_period(c, p);
          check(p == 256 * (ps[c] + 1), "R1 period", p, 256 * (ps[c] + 1));
        end
      end
      prev_max = (ps[0] > ps[1]) ? ps[0] : ps[1];
    end

    // swapped channel codes: pin0 code 11, pin1 code 10
    psc0 = 8'h00; pwm0 = 8'h00; psc1 = 8'h00; pwm1 = 8'hFF;
    sel = 8'h0B;
    cycles(256 * (prev_max + 1) + 4);
    count_active(0, 256, v);
    check(v == 1, "R4 pin0 follows ch1", v, 1);
    count_active(1, 256, v);
    check(v == 256, "R4 pin1 follows ch0", v, 256);

    sel = 8'h00; cycles(2);
    check(drv == 2'b11, "R3 code 00 on both", drv, 3);
    sel = 8'h05; cycles(2);
    check(drv == 2'b00, "R3 code 01 off both", drv, 0);
    sel = 8'hF4; cycles(2);
    check(drv == 2'b01, "R7 upper selector bits ignored", drv, 1);
    sel = 8'h54; cycles(2);
    check(drv == 2'b01, "R7 upper selector bits ignored alt", drv, 1);

    // mid-period threshold change must wait for the wrap
    sel = 8'h02;
    pwm0 = 8'h80;
    cycles(600);
    wait_rise(0);
    pwm0 = 8'hC0;
    count_active(0, 100, v);
    check(v == 100, "R5 change deferred to wrap", v, 100);
    cycles(300);
    count_active(0, 256, v);
    check(v == 64, "R5 new threshold adopted", v, 64);

    // strobe held off: outputs frozen
    tick = 1'b0;
    cycles(2);
    begin
      logic last;
      int chg;
      last = drv[0];
      chg = 0;
      for (int i = 0; i < 600; i++) begin
        @(negedge clk);
        if (drv[0] != last) chg++;
        last = drv[0];
      end
      check(chg == 0, "R8 no motion without strobe", chg, 0);
    end
    tick = 1'b1;
    count_active(0, 256, v);
    check(v == 64, "R8 resumes after strobe", v, 64);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule